// File: doc/BRIEF.md
# Program Memory CRC Scanner with Latched Failure Interrupt

This block checks the integrity of a stretch of word-organised program memory. When pulsed, it walks a region given by a first word address and a word count. It fetches one 16-bit word every three clock cycles and folds each word into a 16-bit CRC. The final word of the region holds the checksum that was computed when the image was built. Folding that word in as well leaves a zero remainder when the memory is intact.

While a scan is running, the block owns the memory read port and holds the processor stall output high. When the last word has been folded in, the block releases the port and writes a pass/fail status bit. If the interrupt enable is high in that cycle and the check failed, it raises a failure interrupt. That interrupt stays latched until reset, so no software action can remove it. A periodic tick can start scans over and over; every scan starts its CRC from the initial value.

Top module: `mem_crc_scanner`

## Requirements
- R1: After reset, `busy_o`, `cpu_stall_o`, `ok_o`, `fail_irq_o` and `mem_rd_o` are all 0.
- R2: A `start_i` pulse seen at a clock edge while idle, with `word_cnt_i` = N > 0, samples `base_addr_i` and N. `busy_o` and `cpu_stall_o` are then high for exactly 3*N cycles, starting with the next cycle.
- R3: Each 3-cycle slot of a scan begins with one cycle where `mem_rd_o` is 1 and `mem_addr_o` is the word address. The addresses run base, base+1, … base+N-1. Read data is taken one cycle after the address (one cycle of latency).
- R4: The CRC uses polynomial 0x1021 (x^16+x^12+x^5+1), initial value 0xFFFF, no reflection and no final XOR. Bits enter MSB first, and each word enters high byte (bits 15:8) first. A scan passes when the CRC over all N words, including the stored checksum in the last word, is 0x0000. The stored checksum is the CRC of the first N-1 words.
- R5: `ok_o` is set to 1 on a pass and 0 on a fail, starting with the first cycle in which `busy_o` is low again.
- R6: `ok_o` reads 0 from the first busy cycle until the result is written.
- R7: A `start_i` pulse while busy is ignored: the running scan keeps its length, its addresses and its result.
- R8: A `start_i` pulse with `word_cnt_i` = 0 is ignored: `busy_o` stays 0 and `ok_o` keeps its value.
- R9: `fail_irq_o` is set by a failing scan only if `irq_en_i` is 1 in the scan's last cycle. The value of `irq_en_i` at start does not matter.
- R10: Once `fail_irq_o` is 1, it stays 1 through later passing scans and through `irq_en_i` going to 0. Only reset clears it.
- R11: Each scan recomputes from the initial value, so a passing scan after a failing scan reports `ok_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Scan request pulse |
| base_addr_i | input | ADDR_W | First word address of the region |
| word_cnt_i | input | CNT_W | Region length in 16-bit words, checksum word included |
| irq_en_i | input | 1 | Failure interrupt enable, sampled in the last scan cycle |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_data_i | input | 16 | Memory read data, one cycle after the address |
| cpu_stall_o | output | 1 | Holds the processor off the memory while scanning |
| busy_o | output | 1 | Scan in progress |
| ok_o | output | 1 | Result of the last scan (1 = pass) |
| fail_irq_o | output | 1 | Latched failure interrupt |

## Verification
The scanner is run on an intact eight-word region, on the same region with one data word changed, on a three-word region elsewhere in memory, and on a one-word region holding 0xFFFF, which is the residue-zero word for the initial value. The intact and corrupted runs separate a correct CRC and comparison from a scanner that always passes or always fails. The second region and the one-word case expose faults in address sampling and in the last-word count. Overlapping start pulses, zero-length requests, and toggling the interrupt enable in the middle of a scan separate the R9 sampling point and the R10 sticky latch from simpler level-driven behaviour.

// File: rtl/crcscan_pkg.sv
package crcscan_pkg;

  typedef enum logic [1:0] {
    SLOT_ADDR = 2'd0,
    SLOT_DATA = 2'd1,
    SLOT_FOLD = 2'd2
  } slot_phase_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  function automatic logic [15:0] crc_fold_word(input logic [15:0] crc_in,
                                                input logic [15:0] word);
    logic [15:0] c;
    logic        fb;
    c = crc_in;
    for (int b = 15; b >= 0; b--) begin
      fb = c[15] ^ word[b];
      c  = {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    end
    return c;
  endfunction

endpackage

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import crcscan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  word_cnt_i,
  input  logic [15:0]       mem_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              busy_o,
  output logic              launch_o,
  output logic              fold_o,
  output logic              last_o,
  output logic [15:0]       word_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  slot_phase_e       phase_q, phase_d;
  logic              busy_q, busy_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  remain_q, remain_d;
  logic [15:0]       word_q, word_d;
  logic              launch;
  logic              capture_en;

  assign launch     = start_i && !busy_q && (word_cnt_i != '0);
  assign capture_en = busy_q && (phase_q == SLOT_DATA);

  always_comb begin
    phase_d  = phase_q;
    busy_d   = busy_q;
    addr_d   = addr_q;
    remain_d = remain_q;
    if (launch) begin
      busy_d   = 1'b1;
      phase_d  = SLOT_ADDR;
      addr_d   = base_addr_i;
      remain_d = word_cnt_i;
    end else if (busy_q) begin
      unique case (phase_q)
        SLOT_ADDR: phase_d = SLOT_DATA;
        SLOT_DATA: phase_d = SLOT_FOLD;
        SLOT_FOLD: begin
          phase_d  = SLOT_ADDR;
          addr_d   = addr_q + ADDR_W'(1);
          remain_d = remain_q - CNT_ONE;
          if (remain_q == CNT_ONE) busy_d = 1'b0;
        end
        default: phase_d = SLOT_ADDR;
      endcase
    end
  end

  always_comb begin
    word_d = word_q;
    if (capture_en) word_d = mem_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= SLOT_ADDR;
      busy_q   <= 1'b0;
      addr_q   <= '0;
      remain_q <= '0;
      word_q   <= '0;
    end else begin
      phase_q  <= phase_d;
      busy_q   <= busy_d;
      addr_q   <= addr_d;
      remain_q <= remain_d;
      word_q   <= word_d;
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_rd_o   = busy_q && (phase_q == SLOT_ADDR);
  assign busy_o     = busy_q;
  assign launch_o   = launch;
  assign fold_o     = busy_q && (phase_q == SLOT_FOLD);
  assign last_o     = busy_q && (phase_q == SLOT_FOLD) && (remain_q == CNT_ONE);
  assign word_o     = word_q;

endmodule

// File: rtl/crc16_engine.sv
module crc16_engine
  import crcscan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear_i,
  input  logic        fold_i,
  input  logic [15:0] word_i,
  output logic [15:0] crc_next_o
);

  logic [15:0] crc_q, crc_d, folded;

  assign folded = crc_fold_word(crc_q, word_i);

  always_comb begin
    crc_d = crc_q;
    if (clear_i)     crc_d = CRC_SEED;
    else if (fold_i) crc_d = folded;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= CRC_SEED;
    else        crc_q <= crc_d;
  end

  assign crc_next_o = folded;

endmodule

// File: rtl/scan_verdict.sv
module scan_verdict (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch_i,
  input  logic        last_i,
  input  logic [15:0] residue_i,
  input  logic        irq_en_i,
  output logic        ok_o,
  output logic        fail_irq_o
);

  logic ok_q, ok_d;
  logic irq_q, irq_d;
  logic mismatch;

  assign mismatch = (residue_i != 16'h0000);

  always_comb begin
    ok_d  = ok_q;
    irq_d = irq_q;
    if (launch_i) ok_d = 1'b0;
    if (last_i) begin
      ok_d = !mismatch;
      if (mismatch && irq_en_i) irq_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ok_q  <= ok_d;
      irq_q <= irq_d;
    end
  end

  assign ok_o       = ok_q;
  assign fail_irq_o = irq_q;

endmodule

// File: rtl/mem_crc_scanner.sv
module mem_crc_scanner #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [CNT_W-1:0]  word_cnt_i,
  input  logic              irq_en_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [15:0]       mem_data_i,
  output logic              cpu_stall_o,
  output logic              busy_o,
  output logic              ok_o,
  output logic              fail_irq_o
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   core_rst_n;
  logic                   launch, fold, last, busy;
  logic [15:0]            word, residue;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign core_rst_n = rst_pipe[SYNC_STAGES-1];

  scan_sequencer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .start_i     (start_i),
    .base_addr_i (base_addr_i),
    .word_cnt_i  (word_cnt_i),
    .mem_data_i  (mem_data_i),
    .mem_addr_o  (mem_addr_o),
    .mem_rd_o    (mem_rd_o),
    .busy_o      (busy),
    .launch_o    (launch),
    .fold_o      (fold),
    .last_o      (last),
    .word_o      (word)
  );

  crc16_engine u_crc (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .clear_i    (launch),
    .fold_i     (fold),
    .word_i     (word),
    .crc_next_o (residue)
  );

  scan_verdict u_verdict (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .launch_i   (launch),
    .last_i     (last),
    .residue_i  (residue),
    .irq_en_i   (irq_en_i),
    .ok_o       (ok_o),
    .fail_irq_o (fail_irq_o)
  );

  assign busy_o      = busy;
  assign cpu_stall_o = busy;

endmodule

// File: rtl/mem_crc_scanner_sva.sv
module mem_crc_scanner_sva #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [ADDR_W-1:0] base_addr_i,
  input logic [CNT_W-1:0]  word_cnt_i,
  input logic              irq_en_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rd_o,
  input logic [15:0]       mem_data_i,
  input logic              cpu_stall_o,
  input logic              busy_o,
  input logic              ok_o,
  input logic              fail_irq_o
);

  assert_launch_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && word_cnt_i != '0 && $past(rst_n)) |=> busy_o);

  assert_launch_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && word_cnt_i != '0 && $past(rst_n)) |=> (mem_rd_o && mem_addr_o == $past(base_addr_i)));

  assert_read_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !mem_rd_o);

  assert_read_in_scan_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> (busy_o && cpu_stall_o));

  assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && !mem_rd_o) |-> $stable(mem_addr_o));

  assert_ok_low_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !ok_o);

  assert_zero_cnt_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !(start_i && word_cnt_i != '0)) |=> !busy_o);

  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fail_irq_o |=> fail_irq_o);

  assert_irq_needs_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_irq_o) |-> ($fell(busy_o) && !ok_o));

endmodule

bind mem_crc_scanner mem_crc_scanner_sva #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_sva (.*);

// File: tb/mem_crc_scanner_bench.sv
module mem_crc_scanner_bench;

  localparam int ADDR_W = 16;
  localparam int CNT_W  = 16;

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic [ADDR_W-1:0] base_addr_i;
  logic [CNT_W-1:0]  word_cnt_i;
  logic              irq_en_i;
  logic [ADDR_W-1:0] mem_addr_o;
  logic              mem_rd_o;
  logic [15:0]       mem_data_i;
  logic              cpu_stall_o;
  logic              busy_o;
  logic              ok_o;
  logic              fail_irq_o;

  logic [15:0] mem [64];
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  mem_crc_scanner #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_mem_crc_scanner (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always_ff @(posedge clk) mem_data_i <= mem[mem_addr_o[5:0]];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_byte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  task automatic build_region(input int base, input int n, input logic [15:0] salt);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < n - 1; i++) begin
      mem[base + i] = 16'(i * 16'h1357) ^ salt;
      c = ref_byte(c, mem[base + i][15:8]);
      c = ref_byte(c, mem[base + i][7:0]);
    end
    mem[base + n - 1] = c;
  endtask

  task automatic do_reset();
    start_i = 0; base_addr_i = '0; word_cnt_i = '0; irq_en_i = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  // mid: 0 none, 1 overlapping start, 2 flip irq enable mid-scan
  task automatic run_scan(input string tag, input int base, input int n, input logic en,
                          input int mid, input logic exp_ok, input logic exp_irq);
    int i = 0;
    int reads = 0;
    start_i = 1; base_addr_i = ADDR_W'(base); word_cnt_i = CNT_W'(n); irq_en_i = en;
    @(negedge clk);
    start_i = 0;
    while (busy_o && i < 1000) begin
      if (i == 0) check({tag, " R6 ok cleared while busy"}, ok_o, 0);
      check({tag, " R2 stall follows busy"}, cpu_stall_o, 1);
      if (mem_rd_o) begin
        check({tag, " R3 read slot position"}, i % 3, 0);
        check({tag, " R3 read address"}, mem_addr_o, ADDR_W'(base + reads));
        reads++;
      end
      if (mid == 1) begin
        start_i = (i == 4); base_addr_i = 16'd50; word_cnt_i = 16'd2;
      end
      if (mid == 2 && i == 2) irq_en_i = !en;
      i++;
      @(negedge clk);
    end
    start_i = 0;
    check({tag, " R2 busy length"}, i, 3 * n);
    check({tag, " R2 stall released"}, cpu_stall_o, 0);
    check({tag, " R3 read count"}, reads, n);
    check({tag, " R5 ok result"}, ok_o, exp_ok);
    check({tag, " R9 irq state"}, fail_irq_o, exp_irq);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 busy", busy_o, 0);
    check("R1 stall", cpu_stall_o, 0);
    check("R1 ok", ok_o, 0);
    check("R1 irq", fail_irq_o, 0);
    check("R1 read", mem_rd_o, 0);
  endtask

  task automatic t_pass();
    build_region(4, 8, 16'hA5C3);
    run_scan("R4 pass", 4, 8, 1, 0, 1, 0);
  endtask

  task automatic t_zero_count();
    start_i = 1; word_cnt_i = '0; base_addr_i = 16'd4;
    @(negedge clk);
    start_i = 0;
    check("R8 zero count busy", busy_o, 0);
    @(negedge clk);
    check("R8 zero count busy later", busy_o, 0);
    check("R8 ok kept", ok_o, 1);
  endtask

  task automatic t_overlap();
    run_scan("R7 overlap", 4, 8, 1, 1, 1, 0);
  endtask

  task automatic t_fail_irq();
    mem[7] = mem[7] ^ 16'h0100;
    run_scan("R4 corrupted", 4, 8, 1, 0, 0, 1);
  endtask

  task automatic t_sticky();
    mem[7] = mem[7] ^ 16'h0100;
    run_scan("R11 recovered", 4, 8, 1, 0, 1, 1);
    irq_en_i = 0;
    repeat (3) @(negedge clk);
    check("R10 irq survives enable low", fail_irq_o, 1);
  endtask

  task automatic t_other_regions();
    build_region(40, 3, 16'h0F0F);
    run_scan("R11 region two", 40, 3, 0, 0, 1, 1);
    mem[60] = 16'hFFFF;
    run_scan("R4 single word", 60, 1, 0, 0, 1, 1);
  endtask

  task automatic t_enable_timing();
    do_reset();
    mem[5] = mem[5] ^ 16'h8000;
    run_scan("R9 enable low at end", 4, 8, 1, 2, 0, 0);
    run_scan("R9 enable high at end", 4, 8, 0, 2, 0, 1);
    mem[5] = mem[5] ^ 16'h8000;
    run_scan("R10 pass after irq", 4, 8, 0, 0, 1, 1);
    rst_n = 0;
    @(negedge clk);
    check("R10 reset clears irq", fail_irq_o, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'(i);
    t_reset();
    t_pass();
    t_zero_count();
    t_overlap();
    t_fail_irq();
    t_sticky();
    t_other_regions();
    t_enable_timing();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule